// File: doc/BRIEF.md
# Frame-Integrity Transmit Frame Selector

In a time-slot switch that keeps frame integrity, every slot taken from one receive frame must leave in the same transmit frame. This block serves one receive/transmit highway pair. It takes a receive frame offset, a transmit frame offset and a highway rate code. It forms the signed difference between the two offsets and compares it with two rate-scaled boundaries. From that comparison it decides whether the data of receive frame N leaves in virtual transmit frame N+1, N+2 or N+3.

The block keeps a two-bit frame counter that advances on each receive frame pulse. That counter is the write page of a four-page frame buffer. The read page trails the write page by the chosen delay. New offsets or a new rate are taken only at a receive frame pulse, so the delay never changes partway through a frame. The delay currently in use is reported on a status output.

Top module: `fi_frame_sel`

## Requirements
- R1: While reset is held and right after it, wr_page is 0, tx_delay is 2 and rd_page is 2.
- R2: wr_page increments by one modulo 4 on each clock edge where rx_fp is high. Otherwise it holds its value.
- R3: At an rx_fp edge, the block computes the difference d = tx_ofs − rx_ofs in quarter-bit units. If d is below the lower boundary, tx_delay becomes 3. The lower boundary is −992 at rate 0, −1984 at rate 1 and −3968 at rate 2, which is 31/32 of a frame.
- R4: If d is at or above the lower boundary and below the upper boundary, tx_delay becomes 2. The upper boundary is 32, 64 or 128 quarter bits at rates 0, 1 and 2, which is 1/32 of a frame.
- R5: If d is at or above the upper boundary, tx_delay becomes 1.
- R6: rate_sel 0, 1 and 2 select 2.048, 4.096 and 8.192 Mbit/s, with frames of 1024, 2048 and 4096 quarter bits. Code 3 is handled exactly like code 2.
- R7: Changes on rx_ofs, tx_ofs or rate_sel between receive frame pulses have no effect on tx_delay. Only the values present at an rx_fp edge are used.
- R8: rd_page always equals wr_page minus tx_delay, modulo 4.
- R9: tx_delay is a plain binary count of extra frames (1, 2 or 3) and is never 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_fp | input | 1 | One-cycle receive frame pulse |
| rx_ofs | input | 12 | Receive frame offset, quarter bits |
| tx_ofs | input | 12 | Transmit frame offset, quarter bits |
| rate_sel | input | 2 | Highway rate code |
| wr_page | output | 2 | Frame buffer page being written |
| rd_page | output | 2 | Frame buffer page being read |
| tx_delay | output | 2 | Transmit frame delay in use (1..3) |

## Verification
The assertions assume that rx_fp is a single-cycle pulse, and that each offset is below the frame length for the rate in use at that pulse. Without that second condition the difference would leave the range in which the boundaries are defined. The stimulus draws every random offset modulo the current frame length. Directed cases place the difference exactly on each boundary and one step below it, and also at both extremes. Between pulses the stimulus changes the configuration inputs freely, to show that they are ignored.

// File: rtl/fi_pkg.sv
`timescale 1ns/1ps
package fi_pkg;
  typedef enum logic [1:0] {
    DLY_N1 = 2'd1,
    DLY_N2 = 2'd2,
    DLY_N3 = 2'd3
  } fi_dly_e;

  // Rate code 3 folds onto the fastest rate.
  function automatic logic [1:0] fi_eff_rate(input logic [1:0] code);
    return (code == 2'd3) ? 2'd2 : code;
  endfunction
endpackage

// File: rtl/fi_bound_gen.sv
`timescale 1ns/1ps
module fi_bound_gen #(
  parameter int OFS_W     = 12,
  parameter int BASE_QB   = 1024,
  parameter int SLOT_SH   = 5,
  localparam int DW       = OFS_W + 2
) (
  input  logic [1:0]          rate_sel,
  output logic signed [DW-1:0] lo_bound,
  output logic signed [DW-1:0] hi_bound
);
  import fi_pkg::*;

  function automatic logic [DW-1:0] frame_len(input logic [1:0] r);
    return DW'(BASE_QB) << fi_eff_rate(r);
  endfunction

  logic [DW-1:0] flen;
  logic [DW-1:0] edge_len;

  always_comb begin
    flen     = frame_len(rate_sel);
    edge_len = flen >> SLOT_SH;
    hi_bound = $signed(edge_len);
    lo_bound = -$signed(flen - edge_len);
  end
endmodule

// File: rtl/fi_delay_pick.sv
`timescale 1ns/1ps
module fi_delay_pick #(
  parameter int OFS_W = 12,
  localparam int DW   = OFS_W + 2
) (
  input  logic [OFS_W-1:0]     rx_ofs,
  input  logic [OFS_W-1:0]     tx_ofs,
  input  logic signed [DW-1:0] lo_bound,
  input  logic signed [DW-1:0] hi_bound,
  output logic signed [DW-1:0] ofs_diff,
  output fi_pkg::fi_dly_e      dly_next
);
  import fi_pkg::*;

  function automatic fi_dly_e pick(input logic signed [DW-1:0] d,
                                   input logic signed [DW-1:0] lo,
                                   input logic signed [DW-1:0] hi);
    if (d < lo)      return DLY_N3;
    else if (d < hi) return DLY_N2;
    else             return DLY_N1;
  endfunction

  always_comb begin
    ofs_diff = $signed({2'b00, tx_ofs}) - $signed({2'b00, rx_ofs});
    dly_next = pick(ofs_diff, lo_bound, hi_bound);
  end
endmodule

// File: rtl/fi_page_seq.sv
`timescale 1ns/1ps
module fi_page_seq #(
  parameter int PG_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rx_fp,
  input  fi_pkg::fi_dly_e dly_next,
  output logic [PG_W-1:0] wr_page,
  output logic [PG_W-1:0] rd_page,
  output fi_pkg::fi_dly_e dly_cur
);
  import fi_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_page <= '0;
      dly_cur <= DLY_N2;
    end else if (rx_fp) begin
      wr_page <= wr_page + PG_W'(1);
      dly_cur <= dly_next;
    end
  end

  assign rd_page = wr_page - PG_W'(dly_cur);
endmodule

// File: rtl/fi_frame_sel.sv
`timescale 1ns/1ps
module fi_frame_sel #(
  parameter int OFS_W   = 12,
  parameter int BASE_QB = 1024,
  parameter int SLOT_SH = 5,
  localparam int DW     = OFS_W + 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_fp,
  input  logic [OFS_W-1:0] rx_ofs,
  input  logic [OFS_W-1:0] tx_ofs,
  input  logic [1:0]       rate_sel,
  output logic [1:0]       wr_page,
  output logic [1:0]       rd_page,
  output logic [1:0]       tx_delay
);
  import fi_pkg::*;

  logic signed [DW-1:0] lo_bound;
  logic signed [DW-1:0] hi_bound;
  logic signed [DW-1:0] ofs_diff;
  fi_dly_e              dly_next;
  fi_dly_e              dly_cur;

  fi_bound_gen #(.OFS_W(OFS_W), .BASE_QB(BASE_QB), .SLOT_SH(SLOT_SH)) u_bounds (
    .rate_sel (rate_sel),
    .lo_bound (lo_bound),
    .hi_bound (hi_bound)
  );

  fi_delay_pick #(.OFS_W(OFS_W)) u_pick (
    .rx_ofs   (rx_ofs),
    .tx_ofs   (tx_ofs),
    .lo_bound (lo_bound),
    .hi_bound (hi_bound),
    .ofs_diff (ofs_diff),
    .dly_next (dly_next)
  );

  fi_page_seq #(.PG_W(2)) u_pages (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_fp    (rx_fp),
    .dly_next (dly_next),
    .wr_page  (wr_page),
    .rd_page  (rd_page),
    .dly_cur  (dly_cur)
  );

  assign tx_delay = dly_cur;
endmodule

// File: rtl/fi_frame_sel_chk.sv
`timescale 1ns/1ps
module fi_frame_sel_chk #(
  parameter int OFS_W = 12,
  localparam int DW   = OFS_W + 2
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 rx_fp,
  input logic [1:0]           wr_page,
  input logic [1:0]           rd_page,
  input logic [1:0]           tx_delay,
  input logic [1:0]           dly_next,
  input logic signed [DW-1:0] lo_bound,
  input logic signed [DW-1:0] hi_bound
);
  assert_wr_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fp |=> wr_page == $past(wr_page) + 2'd1);

  assert_wr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_fp |=> $stable(wr_page));

  assert_delay_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_fp |=> $stable(tx_delay));

  assert_delay_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_fp |=> tx_delay == $past(dly_next));

  assert_rd_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fp && dly_next == tx_delay) |=> rd_page == $past(rd_page) + 2'd1);

  assert_dly_nonzero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_delay != 2'd0 && dly_next != 2'd0);

  assert_bounds_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    lo_bound < 0 && hi_bound > 0);
endmodule

bind fi_frame_sel fi_frame_sel_chk #(.OFS_W(OFS_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rx_fp    (rx_fp),
  .wr_page  (wr_page),
  .rd_page  (rd_page),
  .tx_delay (tx_delay),
  .dly_next (dly_next),
  .lo_bound (lo_bound),
  .hi_bound (hi_bound)
);

// File: tb/fi_frame_sel_tb.sv
`timescale 1ns/1ps
module fi_frame_sel_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_fp = 1'b0;
  logic [11:0] rx_ofs = '0;
  logic [11:0] tx_ofs = '0;
  logic [1:0]  rate_sel = '0;
  logic [1:0]  wr_page, rd_page, tx_delay;

  int checks = 0;
  int fails  = 0;
  int m_wr   = 0;
  int m_dly  = 2;
  bit done   = 0;

  always #10 clk = ~clk;

  fi_frame_sel u_dut (
    .clk(clk), .rst_n(rst_n), .rx_fp(rx_fp), .rx_ofs(rx_ofs),
    .tx_ofs(tx_ofs), .rate_sel(rate_sel), .wr_page(wr_page),
    .rd_page(rd_page), .tx_delay(tx_delay)
  );

  // Slots per frame for a rate code; code 3 behaves as code 2 (R6).
  function automatic int slots_of(int r);
    case (r)
      0: return 32;
      1: return 64;
      default: return 128;
    endcase
  endfunction

  // Each slot is 8 bits of 4 quarter bits.
  function automatic int expect_dly(int rx, int tx, int r);
    int s, lo, hi, d;
    s  = slots_of(r);
    lo = -((s * 31) / 32) * 32;
    hi = (s / 32) * 32;
    d  = tx - rx;
    if (d < lo) return 3;
    if (d < hi) return 2;
    return 1;
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse(int rx, int tx, int r, string req);
    int flen;
    @(negedge clk);
    rx_ofs = 12'(rx); tx_ofs = 12'(tx); rate_sel = 2'(r); rx_fp = 1'b1;
    @(negedge clk);
    rx_fp = 1'b0;
    m_wr  = (m_wr + 1) % 4;
    m_dly = expect_dly(rx, tx, r);
    check({req, " delay"}, tx_delay, m_dly);
    check("R2 wr_page", wr_page, m_wr);
    check("R8 rd_page", rd_page, (m_wr - m_dly + 4) % 4);
    // Disturb configuration between pulses (R7).
    flen = slots_of(r) * 32;
    rx_ofs = 12'($urandom % flen); tx_ofs = 12'($urandom % flen);
    rate_sel = 2'($urandom % 4);
    @(negedge clk);
    check("R7 delay held", tx_delay, m_dly);
    check("R2 wr_page held", wr_page, m_wr);
  endtask

  task automatic at_diff(int d, int r, string req);
    if (d >= 0) pulse(0, d, r, req);
    else        pulse(-d, 0, r, req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check("R1 wr_page", wr_page, 0);
    check("R1 tx_delay", tx_delay, 2);
    check("R1 rd_page", rd_page, 2);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", tx_delay, 2);

    // Directed boundary cases per rate (R3, R4, R5, R6).
    for (int r = 0; r < 4; r++) begin
      int s, lo, hi, fl;
      s  = slots_of(r);
      lo = -((s * 31) / 32) * 32;
      hi = (s / 32) * 32;
      fl = s * 32;
      at_diff(-(fl - 1), r, "R3 extreme");
      at_diff(lo - 1, r, "R3 below lower");
      at_diff(lo, r, "R4 at lower");
      at_diff(0, r, "R4 zero");
      at_diff(hi - 1, r, "R4 below upper");
      at_diff(hi, r, "R5 at upper");
      at_diff(fl - 1, r, "R5 extreme");
    end
    // Rate 3 matches rate 2 where rates 0 and 2 differ (R6).
    at_diff(-2000, 3, "R6 code3");
    at_diff(100, 3, "R6 code3 hi");

    // Constrained random offsets within the frame.
    for (int i = 0; i < 400; i++) begin
      int r, fl;
      r  = $urandom % 4;
      fl = slots_of(r) * 32;
      pulse($urandom % fl, $urandom % fl, r, "R3/R4/R5 random");
      check("R9 nonzero", int'(tx_delay != 0), 1);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule